// File: doc/BRIEF.md
# Slewing Clock Offset Corrector

This block removes a phase error from a free-running time counter by spreading the correction over many small steps, so the counter never jumps. Software loads one parameter set with five 16-bit writes. The set holds a direction, a step size in nanoseconds, a gap and a step count of up to 30 bits. The gap is the number of enabled idle cycles between two steps. Once the set is loaded, the corrector issues the programmed number of steps. On each step cycle the increment handed to the time counter becomes the nominal increment plus the step size, or minus it, with saturation at the bounds.

A separate control write turns the correction on or off. While it is off, the remaining count and the spacing are frozen. A status word reports the enable and whether a correction is still in progress. A new parameter set takes effect as soon as its fifth word lands, even in the middle of a run. The time counter and any direct time load are not part of this block. No data stream passes through it, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `slew_offset_corr`

## Requirements
- R1: Parameter writes on `cfg_wr` fill five words in a fixed order. Word 0 holds the direction in bit 15 (1 means subtract). Word 1 holds the step size in bits 3:0. Word 2 holds the gap. Word 3 holds count bits 15:0. Word 4 holds count bits 29:16 in its bits 13:0. The fifth write commits the set, and the next write is word 0 again.
- R2: A `ctl_wr` loads the enable from `ctl_wdata` bit 14. Steps occur only while the enable is set. While it is clear, the remaining count and the gap spacing hold their values.
- R3: `stat_word` bit 13 shows a correction in progress and bit 14 shows the enable. All other bits read zero.
- R4: After a commit with a nonzero count, `slew_active` is high in the following cycle. If the enable is set, the first step also falls in that cycle.
- R5: Consecutive steps are separated by exactly the programmed gap of enabled non-step cycles. A gap of 0 gives a step on every enabled cycle.
- R6: Exactly the programmed number of steps is issued, and each step lowers the remaining count by one. `slew_active` drops in the cycle after the last step.
- R7: Committing a count of zero produces no steps and leaves `slew_active` low. This also holds when a correction was in progress.
- R8: A commit during a running correction replaces the remaining count, direction, step size and gap, and restarts the spacing.
- R9: `tick_inc` equals `nom_inc` in cycles without a step. On a step it is `nom_inc` plus the step size when adding, and `nom_inc` minus the step size when subtracting.
- R10: A subtracting step never takes `tick_inc` below 0, and an adding step never takes it above 255.
- R11: After reset the enable is clear, no correction is active, and the write sequence starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Parameter word write strobe |
| cfg_wdata | input | 16 | Parameter word |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control word, bit 14 is the enable |
| nom_inc | input | 8 | Nominal per-cycle increment in ns |
| tick_inc | output | 8 | Increment to apply this cycle |
| slew_step | output | 1 | A correction step is applied this cycle |
| slew_active | output | 1 | Correction in progress |
| stat_word | output | 16 | Status: bit 13 active, bit 14 enable |

## Verification
The assertions check on every cycle that each step lowers the remaining count by one and that a nonzero gap forbids back-to-back steps. They also check that a disabled corrector freezes its state, that the flag drops after the last step, that a loaded count of zero or nonzero sets the flag accordingly, and that the increment only moves in the programmed direction. Only the bench scenarios can show the complete step pattern for a given gap and count, the exact saturated increment values, and that a commit in the middle of a run really discards the old remaining count. The same holds for the high count word being taken from the fifth write, and for a paused run resuming where it stopped.

// File: rtl/slew_pkg.sv
package slew_pkg;
  localparam int WORD_W   = 16;
  localparam int SIGN_BIT = 15;
  localparam int ACT_BIT  = 13;
  localparam int EN_BIT   = 14;

  typedef enum logic [2:0] {
    W_SIGN   = 3'd0,
    W_STEP   = 3'd1,
    W_GAP    = 3'd2,
    W_CNT_LO = 3'd3,
    W_CNT_HI = 3'd4
  } word_e;
endpackage

// File: rtl/slew_cfg_loader.sv
module slew_cfg_loader
  import slew_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int GAP_W  = 16,
  parameter int CNT_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              commit,
  output logic              neg,
  output logic [STEP_W-1:0] step_ns,
  output logic [GAP_W-1:0]  gap,
  output logic [CNT_W-1:0]  count
);
  localparam int CNT_HI_W = CNT_W - WORD_W;

  word_e             idx_q;
  logic              sign_q;
  logic [STEP_W-1:0] step_q;
  logic [GAP_W-1:0]  gap_q;
  logic [WORD_W-1:0] cnt_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= W_SIGN;
      sign_q   <= 1'b0;
      step_q   <= '0;
      gap_q    <= '0;
      cnt_lo_q <= '0;
    end else if (wr) begin
      case (idx_q)
        W_SIGN:   sign_q   <= wdata[SIGN_BIT];
        W_STEP:   step_q   <= wdata[STEP_W-1:0];
        W_GAP:    gap_q    <= wdata[GAP_W-1:0];
        W_CNT_LO: cnt_lo_q <= wdata;
        default:  ;
      endcase
      idx_q <= (idx_q == W_CNT_HI) ? W_SIGN : word_e'(idx_q + 3'd1);
    end
  end

  assign commit  = wr && (idx_q == W_CNT_HI);
  assign neg     = sign_q;
  assign step_ns = step_q;
  assign gap     = gap_q;
  assign count   = {wdata[CNT_HI_W-1:0], cnt_lo_q};

  p_idx_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= W_CNT_HI);
  p_commit_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (idx_q == W_SIGN));
endmodule

// File: rtl/slew_step_engine.sv
module slew_step_engine #(
  parameter int STEP_W = 4,
  parameter int GAP_W  = 16,
  parameter int CNT_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ld_neg,
  input  logic [STEP_W-1:0] ld_step,
  input  logic [GAP_W-1:0]  ld_gap,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              en,
  output logic              step,
  output logic              step_neg,
  output logic [STEP_W-1:0] step_ns,
  output logic              active
);
  logic [CNT_W-1:0]  rem_q;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gap_cnt_q;
  logic              neg_q;
  logic [STEP_W-1:0] step_q;

  assign active   = (rem_q != '0);
  assign step     = active && en && (gap_cnt_q == '0);
  assign step_neg = neg_q;
  assign step_ns  = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= '0;
      gap_q     <= '0;
      gap_cnt_q <= '0;
      neg_q     <= 1'b0;
      step_q    <= '0;
    end else if (load) begin
      rem_q     <= ld_count;
      gap_q     <= ld_gap;
      gap_cnt_q <= '0;
      neg_q     <= ld_neg;
      step_q    <= ld_step;
    end else if (step) begin
      rem_q     <= rem_q - CNT_W'(1);
      gap_cnt_q <= gap_q;
    end else if (en && active && (gap_cnt_q != '0)) begin
      gap_cnt_q <= gap_cnt_q - GAP_W'(1);
    end
  end

  p_step_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
  p_last_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rem_q == CNT_W'(1)) |=> !active);
  p_gap_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && gap_q != '0) |=> !step);
  p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && gap_q == '0 && rem_q > CNT_W'(1)) |=> (step || !en));
  p_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(rem_q) && $stable(gap_cnt_q)));
  p_zero_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_count == '0) |=> !active);
  p_load_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_count != '0) |=> active);
endmodule

// File: rtl/slew_inc_apply.sv
module slew_inc_apply #(
  parameter int INC_W    = 8,
  parameter int STEP_W   = 4,
  parameter bit SATURATE = 1'b1
) (
  input  logic [INC_W-1:0]  nom_inc,
  input  logic              step,
  input  logic              step_neg,
  input  logic [STEP_W-1:0] step_ns,
  output logic [INC_W-1:0]  tick_inc
);
  localparam int PAD_W = INC_W + 1 - STEP_W;

  logic [INC_W:0]   up_sum;
  logic [INC_W:0]   dn_sum;
  logic [INC_W-1:0] up_fin;
  logic [INC_W-1:0] dn_fin;

  assign up_sum = {1'b0, nom_inc} + {{PAD_W{1'b0}}, step_ns};
  assign dn_sum = {1'b0, nom_inc} - {{PAD_W{1'b0}}, step_ns};

  generate
    if (SATURATE) begin : g_sat
      assign up_fin = up_sum[INC_W] ? {INC_W{1'b1}} : up_sum[INC_W-1:0];
      assign dn_fin = dn_sum[INC_W] ? {INC_W{1'b0}} : dn_sum[INC_W-1:0];
    end else begin : g_wrap
      assign up_fin = up_sum[INC_W-1:0];
      assign dn_fin = dn_sum[INC_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!step)         tick_inc = nom_inc;
    else if (step_neg) tick_inc = dn_fin;
    else               tick_inc = up_fin;
  end
endmodule

// File: rtl/slew_offset_corr.sv
module slew_offset_corr
  import slew_pkg::*;
#(
  parameter int INC_W  = 8,
  parameter int STEP_W = 4,
  parameter int GAP_W  = 16,
  parameter int CNT_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  input  logic [INC_W-1:0]  nom_inc,
  output logic [INC_W-1:0]  tick_inc,
  output logic              slew_step,
  output logic              slew_active,
  output logic [15:0]       stat_word
);
  logic              commit;
  logic              ld_neg;
  logic [STEP_W-1:0] ld_step;
  logic [GAP_W-1:0]  ld_gap;
  logic [CNT_W-1:0]  ld_count;
  logic              en_q;
  logic              step_neg;
  logic [STEP_W-1:0] step_ns;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_wdata[EN_BIT];
  end

  slew_cfg_loader #(.STEP_W(STEP_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .commit(commit), .neg(ld_neg), .step_ns(ld_step), .gap(ld_gap),
    .count(ld_count)
  );

  slew_step_engine #(.STEP_W(STEP_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .load(commit), .ld_neg(ld_neg),
    .ld_step(ld_step), .ld_gap(ld_gap), .ld_count(ld_count), .en(en_q),
    .step(slew_step), .step_neg(step_neg), .step_ns(step_ns),
    .active(slew_active)
  );

  slew_inc_apply #(.INC_W(INC_W), .STEP_W(STEP_W), .SATURATE(1'b1)) u_apply (
    .nom_inc(nom_inc), .step(slew_step), .step_neg(step_neg),
    .step_ns(step_ns), .tick_inc(tick_inc)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ACT_BIT] = slew_active;
    stat_word[EN_BIT]  = en_q;
  end

  p_enable_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (stat_word[EN_BIT] == $past(ctl_wdata[EN_BIT])));
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_word[EN_BIT] |-> !slew_step);
  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slew_step |-> (tick_inc == nom_inc));
  p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_step && step_neg) |-> (tick_inc <= nom_inc));
  p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_step && !step_neg) |-> (tick_inc >= nom_inc));
endmodule

// File: tb/slew_offset_corr_tb_top.sv
module slew_offset_corr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [7:0]  nom_inc = 8'd8;
  logic [7:0]  tick_inc;
  logic        slew_step;
  logic        slew_active;
  logic [15:0] stat_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slew_offset_corr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .nom_inc(nom_inc),
    .tick_inc(tick_inc), .slew_step(slew_step), .slew_active(slew_active),
    .stat_word(stat_word)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_inc(int nom, bit fire, bit neg, int stp);
    int v;
    if (!fire) return nom;
    v = neg ? nom - stp : nom + stp;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic wr_word(logic [15:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_ctl(logic [15:0] d);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic program_set(bit neg, int stp, int gap, longint cnt);
    logic [29:0] c30;
    c30 = cnt[29:0];
    wr_word({neg, 15'd0});
    wr_word(16'(stp));
    wr_word(16'(gap));
    wr_word(c30[15:0]);
    wr_word({2'b00, c30[29:16]});
  endtask

  task automatic observe(bit neg, int stp, int gap, int cnt, string tick_req);
    int total;
    int seen;
    bit es;
    bit ea;
    total = (cnt == 0) ? 3 : (cnt - 1) * (gap + 1) + 4;
    seen = 0;
    for (int c = 0; c < total; c++) begin
      es = (cnt > 0) && (c % (gap + 1) == 0) && (c / (gap + 1) < cnt);
      ea = (cnt > 0) && (c <= (cnt - 1) * (gap + 1));
      if (c == 0) check(slew_step == es, "R4", "first step", slew_step, es);
      else        check(slew_step == es, "R5", "step spacing", slew_step, es);
      check(slew_active == ea, "R6", "active flag", slew_active, ea);
      check(tick_inc == 8'(exp_inc(nom_inc, es, neg, stp)), tick_req, "tick_inc",
            tick_inc, exp_inc(nom_inc, es, neg, stp));
      if (slew_step) seen++;
      @(negedge clk);
    end
    check(seen == cnt, "R6", "step total", seen, cnt);
  endtask

  task automatic run_set(bit neg, int stp, int gap, int cnt, string tick_req);
    program_set(neg, stp, gap, cnt);
    observe(neg, stp, gap, cnt, tick_req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51e7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(stat_word == 16'h0000, "R11", "status after reset", stat_word, 0);
    check(slew_step == 1'b0, "R11", "no step after reset", slew_step, 0);
    check(tick_inc == nom_inc, "R11", "tick after reset", tick_inc, nom_inc);

    // R2 R3 enable and status
    wr_ctl(16'h4000);
    check(stat_word == 16'h4000, "R3", "status enabled idle", stat_word, 16'h4000);

    // directed runs: gap 0 and gap 3
    nom_inc = 8'd8;
    run_set(1'b0, 7, 0, 4, "R9");
    nom_inc = 8'd40;
    run_set(1'b1, 7, 3, 3, "R9");

    // R7 zero count when idle
    run_set(1'b0, 5, 1, 0, "R9");

    // R1 high count word: only bit 16 set
    program_set(1'b0, 1, 0, 30'h10000);
    check(slew_active == 1'b1, "R1", "high word count active", slew_active, 1);
    check(stat_word == 16'h6000, "R3", "status running", stat_word, 16'h6000);
    repeat (4) begin
      check(slew_step == 1'b1, "R5", "gap0 every cycle", slew_step, 1);
      @(negedge clk);
    end
    // R7 zero count while active stops the run
    run_set(1'b0, 1, 0, 0, "R9");
    check(stat_word == 16'h4000, "R7", "status after zero load", stat_word, 16'h4000);

    // R10 saturation both ways
    nom_inc = 8'd250;
    run_set(1'b0, 15, 0, 2, "R10");
    nom_inc = 8'd3;
    run_set(1'b1, 7, 1, 2, "R10");

    // R8 replace a running correction
    nom_inc = 8'd100;
    program_set(1'b0, 9, 3, 40);
    repeat (5) @(negedge clk);
    check(slew_active == 1'b1, "R8", "old run active", slew_active, 1);
    run_set(1'b1, 2, 1, 3, "R9");
    check(slew_active == 1'b0, "R8", "old count discarded", slew_active, 0);

    // R2 pause and resume
    wr_ctl(16'h0000);
    program_set(1'b0, 5, 1, 3);
    repeat (6) begin
      check(slew_step == 1'b0, "R2", "no step while disabled", slew_step, 0);
      check(stat_word == 16'h2000, "R2", "paused status", stat_word, 16'h2000);
      @(negedge clk);
    end
    wr_ctl(16'h4000);
    observe(1'b0, 5, 1, 3, "R9");

    // random mix
    for (int k = 0; k < 20; k++) begin
      bit rn;
      int rs;
      int rg;
      int rc;
      rn = 1'($urandom_range(0, 1));
      rs = int'($urandom_range(1, 15));
      rg = int'($urandom_range(0, 3));
      rc = int'($urandom_range(1, 6));
      nom_inc = 8'($urandom_range(0, 255));
      run_set(rn, rs, rg, rc, "R9");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule